// File: doc/BRIEF.md
# Multiplexed External Bus Address Sequencer

This block runs single read transactions from an on-chip host to one asynchronous external memory behind one chip select. The host raises a request with a 27-bit byte address. The block then walks the external pins through one or two address phases, a read phase and an acknowledge cycle. It returns the read word with a one-cycle acknowledge.

How the address reaches the memory depends on three strap inputs, which are sampled while reset is held. The bus mode strap picks one of three modes. The first is a plain mode, where the full address sits on dedicated address lines. The second is a combined mode, where the low address half shares the data lines and the upper bits use the dedicated lines. The third is a double-address mode, where the entire address crosses the data lines in two strobe phases. The width strap selects an 8-bit or 16-bit device. The wait strap decides whether the device's wait line can stretch the read phase.

All cycle counts are fixed parameters rather than software registers, so the block is usable straight out of reset.

Top module: `mxbus_addr_seq`

## Requirements
- R1: The straps are loaded on every clock edge while rst_n_i is low, so the value present at the last reset edge wins. Changes on the strap pins after reset release have no effect until the next reset.
- R2: On the clock edge after reset, and while reset stays low, the outputs hold their idle values: ack_o=0, err_o=0, cs_n_o=1, adv_n_o=1, oe_n_o=1 and ad_oe_o=0.
- R3: In plain mode (bus mode strap 00), exactly one address phase occurs. In it, adv_n_o is low for 2 clocks and a_o equals the full request address. ad_oe_o stays 0 for the whole transaction.
- R4: In combined mode (bus mode strap 10), exactly one address phase of 2 low adv_n_o clocks occurs. During it, ad_o equals address bits 15..0 with ad_oe_o=1, and a_o equals address bits 26..16 in positions 26..16 with zeros below.
- R5: In double-address mode (bus mode strap 01), two address phases occur, each with adv_n_o low for 2 clocks and ad_oe_o=1. Exactly 1 clock with adv_n_o high separates them. The first phase drives ad_o with address bits 26..17, zero-extended. The second drives address bits 16..1. a_o is 0 in both phases.
- R6: After the last address phase, ad_oe_o is 0 while oe_n_o is low. Without wait stretching, oe_n_o is low for exactly 4 clocks.
- R7: When the wait strap is 1, every clock in which wait_i[0] is high during the read phase adds one clock to the low time of oe_n_o. When the wait strap is 0, wait_i[0] has no effect. wait_i[1] never has an effect.
- R8: The read word is taken from ad_i at the last clock of oe_n_o low. For a 16-bit device (width strap 01) it is the full ad_i. For an 8-bit device (width strap 00) it is ad_i[7:0] zero-extended. The word is then presented with a single-cycle ack_o, with err_o=0. In that cycle oe_n_o=1 and cs_n_o=0, and cs_n_o is 1 on the following clock. In plain and combined mode, ack_o arrives 7 clocks plus any wait clocks after the accepting edge. In double-address mode it arrives 10 clocks plus any wait clocks after that edge.
- R9: A request is acknowledged one clock after acceptance with err_o=1 and no bus activity (cs_n_o, adv_n_o and oe_n_o remain 1) in three cases: the bus mode strap is 11, the width strap is 10 or 11, or double-address mode is combined with the 8-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| strap_mux_i | input | 2 | Bus mode strap: 00 plain, 01 double-address, 10 combined, 11 reserved |
| strap_size_i | input | 2 | Device width strap: 00 8-bit, 01 16-bit, 1x reserved |
| strap_wait_en_i | input | 1 | Wait monitoring strap: 1 lets wait_i[0] stretch reads |
| req_i | input | 1 | Host read request, held until ack_o |
| addr_i | input | 27 | Host byte address, taken when the request is accepted |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with ack_o |
| rdata_o | output | 16 | Read word, valid with ack_o |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address-valid strobe, active low, rising edge marks an address phase |
| oe_n_o | output | 1 | Output enable, active low |
| ad_o | output | 16 | Shared address/data lines, address value |
| ad_oe_o | output | 1 | Drive enable for ad_o; 0 means the shared lines float |
| ad_i | input | 16 | Shared address/data lines, data from the memory |
| a_o | output | 27 | Dedicated address lines |
| wait_i | input | 2 | Wait lines, active high; only line 0 is monitored |

## Verification
The bench builds the block with its default parameters: a 27-bit address, 16 shared lines, two wait lines, 2-clock strobes, a 1-clock gap and a 4-clock read phase. These values make the double-address split fall at bits 26..17 and 16..1. They also make the acknowledge latencies exactly 7 and 10 clocks plus wait clocks, which the bench predicts. With two wait lines, the bench can toggle the unmonitored line freely and show that it is ignored. Each strap combination is loaded through its own reset, with junk on the strap pins before and after the load. This exercises every legal and illegal mode.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

   typedef enum logic [1:0] {
      MUX_PLAIN = 2'b00,
      MUX_AAD   = 2'b01,
      MUX_AD    = 2'b10,
      MUX_RSV   = 2'b11
   } mux_mode_t;

   localparam logic [1:0] SZ_8BIT  = 2'b00;
   localparam logic [1:0] SZ_16BIT = 2'b01;

   typedef struct packed {
      mux_mode_t  mux;
      logic [1:0] size;
      logic       wait_en;
   } strap_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PH1  = 3'd1,
      ST_GAP  = 3'd2,
      ST_PH2  = 3'd3,
      ST_RD   = 3'd4,
      ST_ACK  = 3'd5,
      ST_ERR  = 3'd6
   } seq_state_t;

endpackage

// File: rtl/mxbus_strap_cap.sv
module mxbus_strap_cap
   import mxbus_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_n_i,
   input  logic [1:0] mux_i,
   input  logic [1:0] size_i,
   input  logic       wait_en_i,
   output strap_cfg_t cfg_o,
   output logic       cfg_ok_o
);

   strap_cfg_t cfg_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cfg_q.mux     <= mux_mode_t'(mux_i);
         cfg_q.size    <= size_i;
         cfg_q.wait_en <= wait_en_i;
      end
   end

   assign cfg_o    = cfg_q;
   assign cfg_ok_o = (cfg_q.mux != MUX_RSV) && !cfg_q.size[1]
                     && !((cfg_q.mux == MUX_AAD) && (cfg_q.size == SZ_8BIT));

   // R1
   strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      1'b1 |=> $stable(cfg_q));

endmodule

// File: rtl/mxbus_addr_fmt.sv
module mxbus_addr_fmt
   import mxbus_pkg::*;
#(
   parameter int ADDR_W = 27,
   parameter int AD_W   = 16
) (
   input  mux_mode_t         mux_i,
   input  logic              phase2_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [AD_W-1:0]   ad_o,
   output logic [ADDR_W-1:0] a_o
);

   localparam int HI_W   = ADDR_W - AD_W;
   localparam int AAD1_W = ADDR_W - 1 - AD_W;

   logic [AD_W-1:0] aad_first;
   logic [AD_W-1:0] aad_second;

   generate
      if (HI_W < 2 || AAD1_W > AD_W) begin : g_bad_split
         $error("mxbus_addr_fmt: address does not split across the shared lines");
      end
      if (AAD1_W == AD_W) begin : g_first_full
         assign aad_first = addr_i[ADDR_W-1:AD_W+1];
      end else begin : g_first_ext
         assign aad_first = {{(AD_W-AAD1_W){1'b0}}, addr_i[ADDR_W-1:AD_W+1]};
      end
   endgenerate

   assign aad_second = addr_i[AD_W:1];

   always_comb begin
      unique case (mux_i)
         MUX_AD: begin
            ad_o = addr_i[AD_W-1:0];
            a_o  = {addr_i[ADDR_W-1:AD_W], {AD_W{1'b0}}};
         end
         MUX_AAD: begin
            ad_o = phase2_i ? aad_second : aad_first;
            a_o  = '0;
         end
         default: begin
            ad_o = '0;
            a_o  = addr_i;
         end
      endcase
   end

endmodule

// File: rtl/mxbus_seq_fsm.sv
module mxbus_seq_fsm
   import mxbus_pkg::*;
#(
   parameter int ADDR_W      = 27,
   parameter int AD_W        = 16,
   parameter int ADV_LOW_CYC = 2,
   parameter int GAP_CYC     = 1,
   parameter int OE_CYC      = 4
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  mux_mode_t         mux_i,
   input  logic [1:0]        size_i,
   input  logic              cfg_ok_i,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wait_act_i,
   input  logic [AD_W-1:0]   ad_i,
   output logic              ack_o,
   output logic              err_o,
   output logic [AD_W-1:0]   rdata_o,
   output logic              cs_n_o,
   output logic              adv_n_o,
   output logic              oe_n_o,
   output logic              drive_o,
   output logic              phase2_o,
   output logic [ADDR_W-1:0] addr_q_o
);

   localparam int BYTE_W  = 8;
   localparam int MAX_AG  = (ADV_LOW_CYC > GAP_CYC) ? ADV_LOW_CYC : GAP_CYC;
   localparam int CNT_MAX = (MAX_AG > OE_CYC) ? MAX_AG : OE_CYC;
   localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] ADV_LAST = CNT_W'(ADV_LOW_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] OE_LAST  = CNT_W'(OE_CYC - 1);

   generate
      if (ADV_LOW_CYC < 1 || GAP_CYC < 1 || OE_CYC < 1) begin : g_bad_cyc
         $error("mxbus_seq_fsm: every phase needs at least one clock");
      end
      if (AD_W <= BYTE_W) begin : g_bad_width
         $error("mxbus_seq_fsm: shared lines must be wider than one byte");
      end
   endgenerate

   seq_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [AD_W-1:0]   rdata_q;
   logic [AD_W-1:0]   rd_word;

   assign rd_word = (size_i == SZ_8BIT) ? {{(AD_W-BYTE_W){1'b0}}, ad_i[BYTE_W-1:0]} : ad_i;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         addr_q  <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  cnt_q   <= '0;
                  addr_q  <= addr_i;
                  state_q <= cfg_ok_i ? ST_PH1 : ST_ERR;
               end
            end
            ST_PH1, ST_PH2: begin
               if (cnt_q == ADV_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ((state_q == ST_PH1) && (mux_i == MUX_AAD)) ? ST_GAP : ST_RD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (cnt_q == GAP_LAST) begin
                  cnt_q   <= '0;
                  state_q <= ST_PH2;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RD: begin
               if (!wait_act_i) begin
                  if (cnt_q == OE_LAST) begin
                     cnt_q   <= '0;
                     rdata_q <= rd_word;
                     state_q <= ST_ACK;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ack_o    = (state_q == ST_ACK) || (state_q == ST_ERR);
   assign err_o    = (state_q == ST_ERR);
   assign rdata_o  = rdata_q;
   assign cs_n_o   = (state_q == ST_IDLE) || (state_q == ST_ERR);
   assign adv_n_o  = !((state_q == ST_PH1) || (state_q == ST_PH2));
   assign oe_n_o   = (state_q != ST_RD);
   assign drive_o  = (state_q == ST_PH1) || (state_q == ST_GAP) || (state_q == ST_PH2);
   assign phase2_o = (state_q == ST_PH2);
   assign addr_q_o = addr_q;

   // R8
   ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ack_o |=> !ack_o);

   // R8
   cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ack_o && !err_o) |=> cs_n_o);

   // R9
   err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      err_o |-> (cs_n_o && adv_n_o && oe_n_o));

   // R5
   gap_before_ph2_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(phase2_o) |-> $past(state_q == ST_GAP));

   // R7
   wait_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!oe_n_o && wait_act_i) |=> !oe_n_o);

endmodule

// File: rtl/mxbus_addr_seq.sv
module mxbus_addr_seq
   import mxbus_pkg::*;
#(
   parameter int ADDR_W      = 27,
   parameter int AD_W        = 16,
   parameter int WAIT_N      = 2,
   parameter int ADV_LOW_CYC = 2,
   parameter int GAP_CYC     = 1,
   parameter int OE_CYC      = 4
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [1:0]        strap_mux_i,
   input  logic [1:0]        strap_size_i,
   input  logic              strap_wait_en_i,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ack_o,
   output logic              err_o,
   output logic [AD_W-1:0]   rdata_o,
   output logic              cs_n_o,
   output logic              adv_n_o,
   output logic              oe_n_o,
   output logic [AD_W-1:0]   ad_o,
   output logic              ad_oe_o,
   input  logic [AD_W-1:0]   ad_i,
   output logic [ADDR_W-1:0] a_o,
   input  logic [WAIT_N-1:0] wait_i
);

   strap_cfg_t        cfg;
   logic              cfg_ok;
   logic              wait_act;
   logic              drive;
   logic              phase2;
   logic [ADDR_W-1:0] addr_q;
   logic [AD_W-1:0]   fmt_ad;
   logic [ADDR_W-1:0] fmt_a;

   generate
      if (WAIT_N < 1) begin : g_bad_wait
         $error("mxbus_addr_seq: at least one wait line is needed");
      end else if (WAIT_N > 1) begin : g_wait_spare
         logic unused_wait_hi;
         assign unused_wait_hi = ^wait_i[WAIT_N-1:1];
      end
   endgenerate

   mxbus_strap_cap u_strap (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .mux_i     (strap_mux_i),
      .size_i    (strap_size_i),
      .wait_en_i (strap_wait_en_i),
      .cfg_o     (cfg),
      .cfg_ok_o  (cfg_ok)
   );

   assign wait_act = cfg.wait_en & wait_i[0];

   mxbus_seq_fsm #(
      .ADDR_W      (ADDR_W),
      .AD_W        (AD_W),
      .ADV_LOW_CYC (ADV_LOW_CYC),
      .GAP_CYC     (GAP_CYC),
      .OE_CYC      (OE_CYC)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .mux_i      (cfg.mux),
      .size_i     (cfg.size),
      .cfg_ok_i   (cfg_ok),
      .req_i      (req_i),
      .addr_i     (addr_i),
      .wait_act_i (wait_act),
      .ad_i       (ad_i),
      .ack_o      (ack_o),
      .err_o      (err_o),
      .rdata_o    (rdata_o),
      .cs_n_o     (cs_n_o),
      .adv_n_o    (adv_n_o),
      .oe_n_o     (oe_n_o),
      .drive_o    (drive),
      .phase2_o   (phase2),
      .addr_q_o   (addr_q)
   );

   mxbus_addr_fmt #(
      .ADDR_W (ADDR_W),
      .AD_W   (AD_W)
   ) u_fmt (
      .mux_i    (cfg.mux),
      .phase2_i (phase2),
      .addr_i   (addr_q),
      .ad_o     (fmt_ad),
      .a_o      (fmt_a)
   );

   assign ad_oe_o = drive && (cfg.mux != MUX_PLAIN);
   assign ad_o    = ad_oe_o ? fmt_ad : '0;
   assign a_o     = cs_n_o ? '0 : fmt_a;

   // R6
   oe_float_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !oe_n_o |-> !ad_oe_o);

   // R3
   plain_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cfg.mux == MUX_PLAIN) |-> !ad_oe_o);

   // R2
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cs_n_o |-> (adv_n_o && oe_n_o && !ad_oe_o));

endmodule

// File: tb/mxbus_addr_seq_tb.sv
`timescale 1ns/1ps
module mxbus_addr_seq_tb_top;

   localparam int ADDR_W = 27;
   localparam int AD_W   = 16;
   localparam int WAIT_N = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        s_mux = 2'b00;
   logic [1:0]        s_size = 2'b01;
   logic              s_wen = 1'b0;
   logic              req = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              ack, err, cs_n, adv_n, oe_n, ad_oe;
   logic [AD_W-1:0]   rdata, ad_out;
   logic [AD_W-1:0]   ad_in = '0;
   logic [ADDR_W-1:0] a_out;
   logic [WAIT_N-1:0] wait_l = '0;

   int checks = 0;
   int errors = 0;
   logic [1:0] c_mux, c_size;
   logic       c_wen;

   mxbus_addr_seq dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .strap_mux_i(s_mux), .strap_size_i(s_size),
      .strap_wait_en_i(s_wen), .req_i(req), .addr_i(addr), .ack_o(ack), .err_o(err),
      .rdata_o(rdata), .cs_n_o(cs_n), .adv_n_o(adv_n), .oe_n_o(oe_n), .ad_o(ad_out),
      .ad_oe_o(ad_oe), .ad_i(ad_in), .a_o(a_out), .wait_i(wait_l)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [AD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
      return a[15:0] ^ a[26:11] ^ 16'h5A3C;
   endfunction

   function automatic bit cfg_legal(input logic [1:0] m, input logic [1:0] s);
      return (m != 2'b11) && !s[1] && !((m == 2'b01) && (s == 2'b00));
   endfunction

   task automatic do_reset(input logic [1:0] m, input logic [1:0] s, input logic w);
      @(negedge clk);
      rst_n = 1'b0; req = 1'b0;
      s_mux = 2'($urandom); s_size = 2'($urandom); s_wen = 1'($urandom);
      repeat (3) @(negedge clk);
      // R2 idle outputs under reset
      chk("R2", "ack", ack, 0); chk("R2", "err", err, 0); chk("R2", "cs_n", cs_n, 1);
      chk("R2", "adv_n", adv_n, 1); chk("R2", "oe_n", oe_n, 1); chk("R2", "ad_oe", ad_oe, 0);
      s_mux = m; s_size = s; s_wen = w;
      c_mux = m; c_size = s; c_wen = w;
      @(negedge clk);
      rst_n = 1'b1;
      // R1 junk on the straps after release must not matter
      s_mux = 2'($urandom); s_size = 2'($urandom); s_wen = 1'($urandom);
      @(negedge clk);
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, input int w);
      bit legal = cfg_legal(c_mux, c_size);
      int nph = 0, low_len = 0, gap = 0, oe_len = 0, drive_bad = 0, lat = 0;
      int ph_len[2];
      logic [AD_W-1:0] ph_ad[2];
      logic ph_oe[2];
      logic [ADDR_W-1:0] ph_a[2];
      logic prev_adv = 1'b1, cs_seen = 1'b0, got = 1'b0;
      logic [AD_W-1:0] last_ad = '0, exp_data;
      logic last_oe = 1'b0;
      logic [ADDR_W-1:0] last_a = '0;
      logic a_err = 1'b0, a_cs = 1'b0, a_oe = 1'b0, post_cs = 1'b0, post_ack = 1'b1;
      logic [AD_W-1:0] a_data = '0;
      int w_eff;
      for (int i = 0; i < 2; i++) begin ph_len[i] = 0; ph_ad[i] = '0; ph_oe[i] = 0; ph_a[i] = '0; end
      @(negedge clk);
      req = 1'b1; addr = a;
      for (int cyc = 1; cyc <= 200; cyc++) begin
         @(negedge clk);
         if (!cs_n) cs_seen = 1'b1;
         if (!adv_n) begin
            low_len++; last_ad = ad_out; last_oe = ad_oe; last_a = a_out;
         end else if (!prev_adv) begin
            if (nph < 2) begin
               ph_len[nph] = low_len; ph_ad[nph] = last_ad; ph_oe[nph] = last_oe; ph_a[nph] = last_a;
            end
            nph++; low_len = 0;
         end
         prev_adv = adv_n;
         if (nph == 1 && adv_n && !cs_n && oe_n && oe_len == 0) gap++;
         if (!oe_n) begin
            oe_len++;
            if (ad_oe) drive_bad++;
         end
         if (ack) begin
            got = 1'b1; lat = cyc; a_err = err; a_cs = cs_n; a_oe = oe_n; a_data = rdata;
            req = 1'b0;
            @(negedge clk);
            post_cs = cs_n; post_ack = ack;
            break;
         end
         if (!oe_n) begin
            ad_in = mem_word(a);
            wait_l[0] = (oe_len <= w);
         end else begin
            ad_in = AD_W'($urandom);
            wait_l[0] = 1'($urandom);
         end
         wait_l[1] = 1'($urandom);
      end
      wait_l = '0;
      req = 1'b0;
      chk("R8", "ack seen", got, 1);
      // R1 legality follows the latched straps, not the pins
      chk("R1", "accepted without error", !a_err, legal);
      if (!legal) begin
         // R9 immediate error, nothing on the bus
         chk("R9", "latency", lat, 1);
         chk("R9", "cs low seen", cs_seen, 0);
         chk("R9", "adv phases", nph, 0);
         chk("R9", "oe clocks", oe_len, 0);
      end else begin
         w_eff = c_wen ? w : 0;
         exp_data = (c_size == 2'b00) ? {8'h00, mem_word(a)[7:0]} : mem_word(a);
         chk("R8", "rdata", a_data, exp_data);
         chk("R8", "cs_n at ack", a_cs, 0);
         chk("R8", "oe_n at ack", a_oe, 1);
         chk("R8", "cs_n after ack", post_cs, 1);
         chk("R8", "ack after ack", post_ack, 0);
         chk("R8", "latency", lat, ((c_mux == 2'b01) ? 10 : 7) + w_eff);
         // R6 read phase length, R7 wait stretching
         chk("R7", "oe clocks", oe_len, 4 + w_eff);
         chk("R6", "ad driven during oe", drive_bad, 0);
         if (c_mux == 2'b00) begin
            chk("R3", "phases", nph, 1);
            chk("R3", "adv low", ph_len[0], 2);
            chk("R3", "ad_oe", ph_oe[0], 0);
            chk("R3", "a lines", ph_a[0], a);
         end else if (c_mux == 2'b10) begin
            chk("R4", "phases", nph, 1);
            chk("R4", "adv low", ph_len[0], 2);
            chk("R4", "ad_oe", ph_oe[0], 1);
            chk("R4", "ad lines", ph_ad[0], a[15:0]);
            chk("R4", "a lines", ph_a[0], {a[26:16], 16'h0000});
         end else begin
            chk("R5", "phases", nph, 2);
            chk("R5", "adv low 1", ph_len[0], 2);
            chk("R5", "adv low 2", ph_len[1], 2);
            chk("R5", "gap", gap, 1);
            chk("R5", "ad_oe 1", ph_oe[0], 1);
            chk("R5", "ad_oe 2", ph_oe[1], 1);
            chk("R5", "ad first", ph_ad[0], {6'b0, a[26:17]});
            chk("R5", "ad second", ph_ad[1], a[16:1]);
            chk("R5", "a lines", ph_a[0] | ph_a[1], 0);
         end
      end
   endtask

   initial begin
      logic [4:0] cfgs[10];
      void'($urandom(32'h2468_1357));
      cfgs[0] = {2'b00, 2'b01, 1'b1}; cfgs[1] = {2'b00, 2'b00, 1'b0};
      cfgs[2] = {2'b10, 2'b01, 1'b1}; cfgs[3] = {2'b10, 2'b00, 1'b1};
      cfgs[4] = {2'b01, 2'b01, 1'b1}; cfgs[5] = {2'b01, 2'b01, 1'b0};
      cfgs[6] = {2'b01, 2'b00, 1'b1}; cfgs[7] = {2'b11, 2'b01, 1'b0};
      cfgs[8] = {2'b00, 2'b10, 1'b1}; cfgs[9] = {2'b10, 2'b11, 1'b0};
      for (int k = 0; k < 10; k++) begin
         do_reset(cfgs[k][4:3], cfgs[k][2:1], cfgs[k][0]);
         do_read('0, 0);
         do_read({ADDR_W{1'b1}}, 3);
         do_read(27'h5555555, 1);
         for (int n = 0; n < 8; n++) do_read(ADDR_W'($urandom), int'($urandom % 4));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule